// File: doc/BRIEF.md
# Calibration Sine Chirp Generator

This block produces signed 16-bit sine samples for a DAC that drives a magnetometer calibration coil. Each sample strobe advances one or two 32-bit phase accumulators by their tuning words. The sine of the accumulated phase is computed by a 16-iteration CORDIC rotation, one iteration per clock. In dual-tone mode two such units run side by side, and each result is halved before the two are added.

A start command latches the operating mode and the two tuning words. In continuous mode the tone or tones play until the next start or a reset. In chirp mode, wraps of tone A's accumulator are counted as completed cycles. After 2^N wraps both tuning words are shifted right by one bit, halving the frequency, and both phases restart at zero. This repeats through a programmed last step, at which point the busy flag drops. The current step index is presented on an output for observation.

Top module: `cal_chirp_gen`

## Requirements
- R1: After reset, busy is 0, stepIdx is 0, dacData is 0 and sampleValid is 0.
- R2: In single-tone mode the k-th sample after start (k from 0) equals 32000*sin(2*pi*k*tuneA/2^32) within 8 LSB, as a two's complement value.
- R3: In dual-tone mode each sample equals 16000*(sin(phase A)+sin(phase B)) within 8 LSB, both phases being tracked as in R2 with their own tuning words.
- R4: The sample for a strobe appears on dacData together with a one-cycle sampleValid pulse exactly 17 clock edges after the edge that samples the strobe. Strobes must be at least 18 cycles apart.
- R5: Sample strobes while busy is 0, or in the same cycle as start, produce no sample and advance no phase.
- R6: In chirp mode (modeChirp=1), a strobe whose phase-A addition carries out of bit 31 completes one cycle. The strobe completing cycle 2^cyclesLog2 of a step that is not lastStep increments stepIdx, shifts both tuning words right by one, and sets both phases to zero for the next sample.
- R7: The strobe completing the last cycle of step lastStep clears busy; that strobe's sample is still delivered and stepIdx keeps its value.
- R8: In continuous mode (modeChirp=0), busy stays 1 and stepIdx stays 0 however many wraps occur.
- R9: A start pulse sets busy in the next cycle, zeroes stepIdx, the cycle count and both phases, and latches modeChirp, modeDual, cyclesLog2, lastStep, tuneA and tuneB, even while a chirp is running.
- R10: Every delivered sample lies within plus or minus 32000 plus 8 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command that latches settings and begins output |
| sampleStrobe | input | 1 | Requests the next sample |
| modeChirp | input | 1 | 1 selects stepped chirp, 0 continuous |
| modeDual | input | 1 | 1 sums two tones, 0 plays tone A alone |
| cyclesLog2 | input | 4 | N: 2^N cycles per chirp step |
| lastStep | input | 4 | Index of the final chirp step |
| tuneA | input | 32 | Phase increment of tone A per sample |
| tuneB | input | 32 | Phase increment of tone B per sample |
| dacData | output | 16 | Signed sample for the DAC |
| sampleValid | output | 1 | One-cycle pulse marking a new dacData |
| busy | output | 1 | Generator is running |
| stepIdx | output | 4 | Current chirp step |

## Verification
The sequencer outputs busy and stepIdx react on the edge that samples start or a strobe, so the bench compares them with its model at the falling edge after every clock. Each sample is due exactly 17 edges after its strobe is sampled. The bench queues the expected value with that due edge number, and at every falling edge it requires sampleValid to be high on exactly the due edges and low on all others. Sample values are computed from real-valued sine functions of the phase the bench tracks itself, so a fixed tolerance covers the CORDIC's rounding.

// File: rtl/cal_chirp_pkg.sv
package cal_chirp_pkg;

  localparam int ACC_W = 32;

  typedef struct packed {
    logic loadTune;  // latch tuning words, clear phases
    logic advance;   // launch a sample and step the phases
    logic restart;   // next step: halve tuning, zero phases
    logic dualSel;   // sum both tones at the output
  } ctrlStrobes_t;

endpackage

// File: rtl/cal_cordic.sv
module cal_cordic
  import cal_chirp_pkg::*;
#(
  parameter int OUT_W = 16,
  parameter int ITER  = 16,
  parameter int AMP   = 32000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch,
  input  logic [ACC_W-1:0]        phase,
  output logic signed [OUT_W-1:0] sine,
  output logic                    done
);

  localparam int DW    = OUT_W + 4;
  localparam int CNT_W = $clog2(ITER);
  localparam int X0    = (AMP * 19899) / 32768;  // gain-compensated start

  function automatic logic [ACC_W-1:0] atanTurn(input int idx);
    case (idx)
      0:  atanTurn = 32'd536870912;
      1:  atanTurn = 32'd316933406;
      2:  atanTurn = 32'd167458907;
      3:  atanTurn = 32'd85004756;
      4:  atanTurn = 32'd42667331;
      5:  atanTurn = 32'd21354465;
      6:  atanTurn = 32'd10679838;
      7:  atanTurn = 32'd5340245;
      8:  atanTurn = 32'd2670163;
      9:  atanTurn = 32'd1335087;
      10: atanTurn = 32'd667544;
      11: atanTurn = 32'd333772;
      12: atanTurn = 32'd166886;
      13: atanTurn = 32'd83443;
      14: atanTurn = 32'd41722;
      15: atanTurn = 32'd20861;
      default: atanTurn = 32'(683565276 >> idx);
    endcase
  endfunction

  logic signed [DW-1:0]    xReg, yReg, xShift, yShift;
  logic signed [ACC_W-1:0] zReg;
  logic [CNT_W-1:0]        iter;
  logic                    active, flip, flipIn;
  logic [ACC_W-1:0]        stepAngle;

  // fold the outer half-circle onto the inner one: sin(p + pi) = -sin(p)
  assign flipIn    = phase[ACC_W-1] ^ phase[ACC_W-2];
  assign xShift    = xReg >>> iter;
  assign yShift    = yReg >>> iter;
  assign stepAngle = atanTurn(int'(iter));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xReg   <= '0;
      yReg   <= '0;
      zReg   <= '0;
      iter   <= '0;
      active <= 1'b0;
      flip   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        xReg   <= DW'(X0);
        yReg   <= '0;
        zReg   <= flipIn ? (phase ^ {1'b1, {(ACC_W-1){1'b0}}}) : phase;
        flip   <= flipIn;
        iter   <= '0;
        active <= 1'b1;
      end else if (active) begin
        if (!zReg[ACC_W-1]) begin
          xReg <= xReg - yShift;
          yReg <= yReg + xShift;
          zReg <= zReg - stepAngle;
        end else begin
          xReg <= xReg + yShift;
          yReg <= yReg - xShift;
          zReg <= zReg + stepAngle;
        end
        iter <= iter + 1'b1;
        if (iter == CNT_W'(ITER - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign sine = OUT_W'(flip ? -yReg : yReg);

endmodule

// File: rtl/cal_chirp_dp.sv
module cal_chirp_dp
  import cal_chirp_pkg::*;
#(
  parameter int OUT_W = 16,
  parameter int ITER  = 16,
  parameter int AMP   = 32000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrlStrobes_t            ctl,
  input  logic [ACC_W-1:0]        tuneA,
  input  logic [ACC_W-1:0]        tuneB,
  output logic                    wrapA,
  output logic signed [OUT_W-1:0] dacData,
  output logic                    sampleValid
);

  localparam int TONES = 2;

  logic [ACC_W-1:0]        tuneIn [TONES];
  logic signed [OUT_W-1:0] sine   [TONES];
  logic [TONES-1:0]        toneDone;
  logic [ACC_W:0]          sumA;
  logic [ACC_W-1:0]        phaseA;
  logic signed [OUT_W-1:0] mixed;

  assign tuneIn[0] = tuneA;
  assign tuneIn[1] = tuneB;

  for (genvar g = 0; g < TONES; g++) begin : g_tone
    logic [ACC_W-1:0] phase, tune;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phase <= '0;
        tune  <= '0;
      end else if (ctl.loadTune) begin
        phase <= '0;
        tune  <= tuneIn[g];
      end else if (ctl.advance) begin
        if (ctl.restart) begin
          phase <= '0;
          tune  <= tune >> 1;
        end else begin
          phase <= phase + tune;
        end
      end
    end

    cal_cordic #(.OUT_W(OUT_W), .ITER(ITER), .AMP(AMP)) i_cordic (
      .clk   (clk),
      .rst_n (rst_n),
      .launch(ctl.advance),
      .phase (phase),
      .sine  (sine[g]),
      .done  (toneDone[g])
    );
  end

  assign phaseA = g_tone[0].phase;
  assign sumA   = {1'b0, phaseA} + {1'b0, g_tone[0].tune};
  assign wrapA  = sumA[ACC_W];

  assign mixed = ctl.dualSel ? ((sine[0] >>> 1) + (sine[1] >>> 1)) : sine[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dacData     <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= &toneDone;
      if (&toneDone) dacData <= mixed;
    end
  end

endmodule

// File: rtl/cal_chirp_ctrl.sv
module cal_chirp_ctrl
  import cal_chirp_pkg::*;
#(
  parameter int LOG_W  = 4,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sampleStrobe,
  input  logic              modeChirp,
  input  logic              modeDual,
  input  logic [LOG_W-1:0]  cyclesLog2,
  input  logic [STEP_W-1:0] lastStep,
  input  logic              wrapA,
  output ctrlStrobes_t      ctl,
  output logic              busy,
  output logic [STEP_W-1:0] stepIdx
);

  localparam int CNT_W = (1 << LOG_W);

  logic [CNT_W-1:0]  cycleCnt, cycleLimit;
  logic [LOG_W-1:0]  logSel;
  logic [STEP_W-1:0] lastSel;
  logic              chirpSel, dualSel;
  logic              advance, stepEnd, finalStep;

  assign cycleLimit = (CNT_W'(1) << logSel) - CNT_W'(1);
  assign advance    = sampleStrobe && busy && !start;
  assign stepEnd    = advance && chirpSel && wrapA && (cycleCnt == cycleLimit);
  assign finalStep  = stepEnd && (stepIdx == lastSel);

  assign ctl.loadTune = start;
  assign ctl.advance  = advance;
  assign ctl.restart  = stepEnd && !finalStep;
  assign ctl.dualSel  = dualSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      stepIdx  <= '0;
      cycleCnt <= '0;
      logSel   <= '0;
      lastSel  <= '0;
      chirpSel <= 1'b0;
      dualSel  <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      stepIdx  <= '0;
      cycleCnt <= '0;
      logSel   <= cyclesLog2;
      lastSel  <= lastStep;
      chirpSel <= modeChirp;
      dualSel  <= modeDual;
    end else if (finalStep) begin
      busy <= 1'b0;
    end else if (stepEnd) begin
      stepIdx  <= stepIdx + 1'b1;
      cycleCnt <= '0;
    end else if (advance && chirpSel && wrapA) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/cal_chirp_gen.sv
module cal_chirp_gen
  import cal_chirp_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int ITER   = 16,
  parameter int AMP    = 32000,
  parameter int LOG_W  = 4,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sampleStrobe,
  input  logic              modeChirp,
  input  logic              modeDual,
  input  logic [LOG_W-1:0]  cyclesLog2,
  input  logic [STEP_W-1:0] lastStep,
  input  logic [31:0]       tuneA,
  input  logic [31:0]       tuneB,
  output logic [OUT_W-1:0]  dacData,
  output logic              sampleValid,
  output logic              busy,
  output logic [STEP_W-1:0] stepIdx
);

  ctrlStrobes_t ctl;
  logic         wrapA;

  cal_chirp_ctrl #(.LOG_W(LOG_W), .STEP_W(STEP_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sampleStrobe(sampleStrobe),
    .modeChirp   (modeChirp),
    .modeDual    (modeDual),
    .cyclesLog2  (cyclesLog2),
    .lastStep    (lastStep),
    .wrapA       (wrapA),
    .ctl         (ctl),
    .busy        (busy),
    .stepIdx     (stepIdx)
  );

  cal_chirp_dp #(.OUT_W(OUT_W), .ITER(ITER), .AMP(AMP)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .tuneA      (tuneA),
    .tuneB      (tuneB),
    .wrapA      (wrapA),
    .dacData    (dacData),
    .sampleValid(sampleValid)
  );

endmodule

// File: rtl/cal_chirp_checker.sv
module cal_chirp_checker #(
  parameter int OUT_W  = 16,
  parameter int AMP    = 32000,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              sampleStrobe,
  input logic              busy,
  input logic [STEP_W-1:0] stepIdx,
  input logic [OUT_W-1:0]  dacData,
  input logic              sampleValid
);

  localparam int LIMIT = AMP + 8;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);  // R4

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));  // R9

  AST_BUSY_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(sampleStrobe) && !$past(start)));  // R7

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stepIdx != $past(stepIdx)) && !$past(start))
      |-> (stepIdx == STEP_W'($past(stepIdx) + 1'b1)));  // R6

  AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stepIdx != $past(stepIdx)) && !$past(start)) |-> $past(sampleStrobe));  // R6

  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> ((int'($signed(dacData)) <= LIMIT) &&
                     (int'($signed(dacData)) >= -LIMIT)));  // R10

endmodule

bind cal_chirp_gen cal_chirp_checker #(.OUT_W(OUT_W), .AMP(AMP), .STEP_W(STEP_W)) i_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .sampleStrobe(sampleStrobe),
  .busy        (busy),
  .stepIdx     (stepIdx),
  .dacData     (dacData),
  .sampleValid (sampleValid)
);

// File: tb/test_cal_chirp_gen.sv
module test_cal_chirp_gen;

  localparam real PI = 3.14159265358979;
  localparam real TWO32 = 4294967296.0;
  localparam int LAT = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic        modeChirp = 1'b0;
  logic        modeDual = 1'b0;
  logic [3:0]  cyclesLog2 = '0;
  logic [3:0]  lastStep = '0;
  logic [31:0] tuneA = '0;
  logic [31:0] tuneB = '0;
  logic [15:0] dacData;
  logic        sampleValid;
  logic        busy;
  logic [3:0]  stepIdx;

  int    testCount = 0;
  int    failCount = 0;
  string curReq = "R1";

  cal_chirp_gen i_cal_chirp_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .sampleStrobe(sampleStrobe),
    .modeChirp(modeChirp), .modeDual(modeDual), .cyclesLog2(cyclesLog2),
    .lastStep(lastStep), .tuneA(tuneA), .tuneB(tuneB), .dacData(dacData),
    .sampleValid(sampleValid), .busy(busy), .stepIdx(stepIdx)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int     edgeNo = 0;
  bit     mBusy = 0, mChirp = 0, mDual = 0;
  int     mStep = 0, mCnt = 0, mLog = 0, mLast = 0;
  longint phA = 0, phB = 0, tA = 0, tB = 0;
  int     dueQ[$];
  real    expQ[$];
  real    tolQ[$];
  bit     dualQ[$];

  always @(posedge clk) begin
    edgeNo++;
    if (!rst_n) begin
      mBusy = 0; mStep = 0; mCnt = 0;
    end else if (start) begin
      mBusy = 1; mStep = 0; mCnt = 0; phA = 0; phB = 0;
      tA = longint'(tuneA); tB = longint'(tuneB);
      mChirp = modeChirp; mDual = modeDual;
      mLog = int'(cyclesLog2); mLast = int'(lastStep);
    end else if (sampleStrobe && mBusy) begin
      real sa, sb;
      bit  wrap;
      sa = $sin(2.0 * PI * real'(phA) / TWO32);
      sb = $sin(2.0 * PI * real'(phB) / TWO32);
      dueQ.push_back(edgeNo + LAT);
      expQ.push_back(mDual ? 16000.0 * (sa + sb) : 32000.0 * sa);
      tolQ.push_back(8.0);
      dualQ.push_back(mDual);
      wrap = (phA + tA) >= longint'(TWO32);
      if (mChirp && wrap && mCnt == (1 << mLog) - 1) begin
        if (mStep == mLast) begin
          mBusy = 0;
          phA = (phA + tA) % longint'(TWO32);
          phB = (phB + tB) % longint'(TWO32);
        end else begin
          mStep++; mCnt = 0; tA = tA >> 1; tB = tB >> 1; phA = 0; phB = 0;
        end
      end else begin
        if (mChirp && wrap) mCnt++;
        phA = (phA + tA) % longint'(TWO32);
        phB = (phB + tB) % longint'(TWO32);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d at edge %0d", req, what, act, exp, edgeNo);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == mBusy, curReq, "busy", longint'(busy), longint'(mBusy));
      check(int'(stepIdx) == mStep, curReq, "stepIdx", longint'(stepIdx), longint'(mStep));
      if (dueQ.size() > 0 && dueQ[0] == edgeNo) begin
        real e, d;
        bit  isDual;
        e = expQ.pop_front();
        d = tolQ.pop_front();
        isDual = dualQ.pop_front();
        void'(dueQ.pop_front());
        check(sampleValid == 1'b1, "R4", "sampleValid on due edge", longint'(sampleValid), 1);
        check(($signed(dacData) - e <= d) && (e - $signed(dacData) <= d),
              isDual ? "R3" : "R2", "dacData", longint'($signed(dacData)), longint'($rtoi(e)));
        check(($signed(dacData) <= 32008) && ($signed(dacData) >= -32008), "R10",
              "range", longint'($signed(dacData)), 32000);
      end else begin
        check(sampleValid == 1'b0, (curReq == "R5") ? "R5" : "R4",
              "sampleValid off due edge", longint'(sampleValid), 0);
      end
    end
  end

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sampleStrobe = 1'b1;
      @(negedge clk) sampleStrobe = 1'b0;
      repeat (19) @(negedge clk);
    end
  endtask

  task automatic doStart(input bit chirp, input bit dual, input int n, input int last,
                         input longint a, input longint b);
    @(negedge clk);
    modeChirp = chirp; modeDual = dual;
    cyclesLog2 = 4'(n); lastStep = 4'(last);
    tuneA = 32'(a); tuneB = 32'(b);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && stepIdx == 0 && dacData == 0 && sampleValid == 0,
          "R1", "reset state", longint'({busy, stepIdx, dacData}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && dacData == 0, "R1", "after reset release", longint'(busy), 0);

    // R5: strobes while idle are ignored
    curReq = "R5";
    strobes(3);

    // R2 / R8: continuous single tone, period 40 samples, several wraps
    curReq = "R8";
    doStart(0, 0, 0, 0, 64'd107374182, 0);
    strobes(90);

    // R3: continuous dual tone
    curReq = "R3";
    doStart(0, 1, 0, 0, 64'd116080197, 64'd390451572);
    strobes(40);

    // R6 / R7: single-tone chirp, 2 cycles per step, steps 0..2
    curReq = "R6";
    doStart(1, 0, 1, 2, 64'd1073741824, 0);
    strobes(56);
    curReq = "R7";
    strobes(2);

    // R5 with start in the same cycle as a strobe
    curReq = "R5";
    @(negedge clk);
    modeChirp = 0; modeDual = 0; tuneA = 32'd171798691; start = 1'b1; sampleStrobe = 1'b1;
    @(negedge clk) start = 1'b0; sampleStrobe = 1'b0;
    repeat (19) @(negedge clk);
    strobes(3);

    // R6 / R7: dual-tone chirp, 1 cycle per step, steps 0..1
    curReq = "R6";
    doStart(1, 1, 0, 1, 64'd536870912, 64'd805306368);
    strobes(24);
    curReq = "R7";
    strobes(2);

    // R9: restart in the middle of a chirp
    curReq = "R9";
    doStart(1, 0, 2, 3, 64'd1073741824, 0);
    strobes(20);
    doStart(0, 0, 0, 0, 64'd171798691, 0);
    strobes(10);

    repeat (30) @(negedge clk);
    check(dueQ.size() == 0, "R4", "all samples delivered", longint'(dueQ.size()), 0);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog: R4 run did not finish, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule